// File: doc/BRIEF.md
# Continuation-Stack Recursive Evaluator

This block computes a doubly recursive integer function in hardware without unrolling it: f(0) = 1, f(1) = 1, and f(n) = 1 + f(n-1) + f(n-2) for n >= 2. It has a single argument/result register and a hardware stack. Each stack entry is a saved continuation, made of a resume tag and one captured value. On every clock the controller performs exactly one combinational step and registers the next state. There are three working states: the call entry, a first resume point that runs after f(n-1) returns, and a second resume point that runs after f(n-2) returns.

A caller presents an 8-bit argument with a one-cycle start while the block is idle. The block first pushes a finish sentinel frame and then recurses. When that sentinel is popped, the block puts the 32-bit result on its output, pulses done for one cycle and goes back to idle.

If a push would go beyond the stack's parameterised depth, the run is aborted to idle and a sticky overflow flag is raised. Only reset clears that flag.

Top module: `rec_eval`

## Requirements
- R1: For an argument of 0 or 1 the reported result is 1.
- R2: For an argument n >= 2 the reported result is 1 + f(n-1) + f(n-2), computed modulo 2^32.
- R3: `done` is high for exactly one cycle per completed run, with `result` valid in that cycle. `result` then holds its value until the next run completes.
- R4: `start` is sampled only while `busy` is low, and `busy` is high in the cycle after an accepted start. A `start` raised while `busy` is high is ignored: it produces no extra run and leaves the running computation's result unchanged.
- R5: In the cycle in which `done` is high the block is already idle, so a `start` in that same cycle is accepted.
- R6: A run of argument n >= 2 needs n stack frames, and a run of argument 0 or 1 needs one frame. A push while all DEPTH frames are occupied sets `overflow`, ends the run at idle and produces no `done`.
- R7: `overflow` stays high until reset, and later runs that fit in the stack complete normally while it is high.
- R8: A low `rst_n` at a clock edge returns the block to idle, empties the stack and clears `overflow`, `done` and `result` to 0. This applies even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with `arg_in` (sampled when idle) |
| arg_in | input | 8 | Function argument n |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 32 | Last computed f(n) |
| overflow | output | 1 | Sticky: a run was aborted for lack of stack |

## Verification
The completion pulse and the acceptance of the next start share a cycle: popping the sentinel returns the controller to idle on the same edge that raises `done`. The bench provokes this by issuing each new argument as soon as `busy` drops, which is the cycle in which `done` is high. It then judges the case two ways: the scoreboard receives every result in order, and `busy` must be high in the following cycle. A second instance with a four-frame stack places the overflow abort next to normal completions, so that the sticky flag is checked against runs that do fit.

// File: rtl/rec_eval_pkg.sv
// Shared types for the recursive evaluator.
// Assumes: three resume tags and four controller states are enough.
package rec_eval_pkg;

    // Resume tag stored in each continuation frame
    typedef enum logic [1:0] {
        TAG_FIN = 2'd0,
        TAG_S1  = 2'd1,
        TAG_S2  = 2'd2
    } tag_e;

    // Controller state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_S1    = 2'd2,
        ST_S2    = 2'd3
    } st_e;

endpackage

// File: rtl/cont_stack.sv
// Continuation stack: LIFO of {resume tag, saved value} frames.
// Assumes: push and pop never arrive in the same cycle. A push while full
// and a pop while empty are both dropped. Clear takes priority over both.
module cont_stack
    import rec_eval_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int VAL_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  tag_e             push_tag,
    input  logic [VAL_W-1:0] push_val,
    output tag_e             top_tag,
    output logic [VAL_W-1:0] top_val,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    tag_e             tag_mem [DEPTH];
    logic [VAL_W-1:0] val_mem [DEPTH];
    logic [LVL_W-1:0] ptr_q;
    logic [IDX_W-1:0] rd_idx;

    assign full    = (ptr_q == LVL_W'(DEPTH));
    assign level   = ptr_q;
    assign rd_idx  = IDX_W'(ptr_q - 1'b1);
    assign top_tag = tag_mem[rd_idx];
    assign top_val = val_mem[rd_idx];

    // Occupancy pointer: reset/clear empties, push grows, pop shrinks
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr_q <= '0;
        end else if (push && !full) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (pop && ptr_q != '0) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

    // Frame storage write on an accepted push
    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            tag_mem[ptr_q[IDX_W-1:0]] <= push_tag;
            val_mem[ptr_q[IDX_W-1:0]] <= push_val;
        end
    end

endmodule

// File: rtl/rec_step.sv
// One combinational evaluation step: from the current state, the argument
// register, the side register and the stack top, it derives the next values
// and the stack command.
// Assumes: a pop is only requested when the stack holds at least one frame.
module rec_step
    import rec_eval_pkg::*;
#(
    parameter int ARG_W = 8,
    parameter int RES_W = 32
) (
    input  st_e              state,
    input  logic [RES_W-1:0] arg_q,
    input  logic [RES_W-1:0] x1_q,
    input  logic             start,
    input  logic [ARG_W-1:0] arg_in,
    input  tag_e             top_tag,
    input  logic [RES_W-1:0] top_val,
    input  logic             full,
    output st_e              state_d,
    output logic [RES_W-1:0] arg_d,
    output logic [RES_W-1:0] x1_d,
    output logic             push,
    output tag_e             push_tag,
    output logic [RES_W-1:0] push_val,
    output logic             pop,
    output logic             finish,
    output logic             abort
);

    // Next-state, datapath and stack command for one step
    always_comb begin
        state_d  = state;
        arg_d    = arg_q;
        x1_d     = x1_q;
        push     = 1'b0;
        push_tag = TAG_FIN;
        push_val = '0;
        pop      = 1'b0;
        finish   = 1'b0;
        abort    = 1'b0;

        case (state)
            ST_IDLE: begin
                if (start) begin
                    push    = 1'b1;
                    arg_d   = RES_W'(arg_in);
                    state_d = ST_ENTRY;
                end
            end
            ST_ENTRY: begin
                if (arg_q > RES_W'(1)) begin
                    push     = 1'b1;
                    push_tag = TAG_S1;
                    push_val = arg_q;
                    arg_d    = arg_q - RES_W'(1);
                end else begin
                    arg_d = RES_W'(1);
                    pop   = 1'b1;
                end
            end
            ST_S1: begin
                push     = 1'b1;
                push_tag = TAG_S2;
                push_val = arg_q;
                arg_d    = x1_q - RES_W'(2);
                state_d  = ST_ENTRY;
            end
            default: begin
                arg_d = RES_W'(1) + x1_q + arg_q;
                pop   = 1'b1;
            end
        endcase

        // Resume the popped continuation
        if (pop) begin
            x1_d = top_val;
            case (top_tag)
                TAG_S1:  state_d = ST_S1;
                TAG_S2:  state_d = ST_S2;
                default: begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            endcase
        end

        // A push with no free frame aborts the run
        if (push && full) begin
            abort   = 1'b1;
            state_d = ST_IDLE;
        end
    end

endmodule

// File: rtl/rec_eval.sv
// Recursive evaluator top: computes f(0)=f(1)=1, f(n)=1+f(n-1)+f(n-2) with
// one argument register, a side register and a continuation stack.
// Assumes: start is sampled only in idle; rst_n is synchronous, active low.
module rec_eval
    import rec_eval_pkg::*;
#(
    parameter int ARG_W = 8,
    parameter int RES_W = 32,
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ARG_W-1:0] arg_in,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             overflow
);

    st_e              state_q, state_d;
    logic [RES_W-1:0] arg_q, arg_d, x1_q, x1_d;
    logic [RES_W-1:0] result_q, push_val, top_val;
    logic             done_q, ovf_q;
    logic             push, pop, finish, abort, full;
    tag_e             push_tag, top_tag;
    logic [LVL_W-1:0] stk_level;

    cont_stack #(.DEPTH(DEPTH), .VAL_W(RES_W)) stack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (abort),
        .push     (push),
        .pop      (pop),
        .push_tag (push_tag),
        .push_val (push_val),
        .top_tag  (top_tag),
        .top_val  (top_val),
        .full     (full),
        .level    (stk_level)
    );

    rec_step #(.ARG_W(ARG_W), .RES_W(RES_W)) step_i (
        .state    (state_q),
        .arg_q    (arg_q),
        .x1_q     (x1_q),
        .start    (start),
        .arg_in   (arg_in),
        .top_tag  (top_tag),
        .top_val  (top_val),
        .full     (full),
        .state_d  (state_d),
        .arg_d    (arg_d),
        .x1_d     (x1_d),
        .push     (push),
        .push_tag (push_tag),
        .push_val (push_val),
        .pop      (pop),
        .finish   (finish),
        .abort    (abort)
    );

    // Controller and datapath registers, one step per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            arg_q   <= '0;
            x1_q    <= '0;
        end else begin
            state_q <= state_d;
            arg_q   <= arg_d;
            x1_q    <= x1_d;
        end
    end

    // Result capture, completion pulse and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) result_q <= arg_d;
            if (abort)  ovf_q    <= 1'b1;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/rec_eval_chk.sv
// Protocol checker for rec_eval, attached by bind.
// Assumes: sampled on the rising clock edge with reset applied from time zero.
module rec_eval_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             overflow,
    input logic [LVL_W-1:0] level
);

    // R3: the completion pulse lasts one cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done coincides with idle
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: an accepted start makes the block busy
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7: overflow is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R6: an overflow abort lands in idle with no completion
    a_r6_overflow_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (!busy && !done));

    // R6: stack occupancy never exceeds its depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

endmodule

bind rec_eval rec_eval_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .overflow (overflow),
    .level    (stk_level)
);

// File: tb/rec_eval_tb_top.sv
// Scoreboard bench: drivers queue expected results, a monitor compares them.
module rec_eval_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_a = 1'b0, start_b = 1'b0;
    logic [7:0]  arg_a = '0, arg_b = '0;
    logic        busy_a, done_a, ovf_a, busy_b, done_b, ovf_b;
    logic [31:0] result_a, result_b;

    int unsigned exp_q [$];
    int          errors = 0;
    int          checks = 0;
    int          b2b_seen = 0;
    int          done_b_cnt = 0;
    int          cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rec_eval dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_a), .arg_in(arg_a),
        .busy(busy_a), .done(done_a), .result(result_a), .overflow(ovf_a)
    );

    rec_eval #(.DEPTH(4)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .start(start_b), .arg_in(arg_b),
        .busy(busy_b), .done(done_b), .result(result_b), .overflow(ovf_b)
    );

    function automatic int unsigned ref_f(input int n);
        int unsigned a = 1, b = 1, c;
        for (int i = 2; i <= n; i++) begin
            c = 1 + a + b;
            b = a;
            a = c;
        end
        return a;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver for the main instance: waits for idle, queues the expectation
    task automatic run_a(input int n, input bit expect_it);
        bit hit;
        while (busy_a) @(negedge clk);
        hit = done_a;
        if (expect_it) exp_q.push_back(ref_f(n));
        #1;
        start_a = 1'b1;
        arg_a   = 8'(n);
        @(negedge clk);
        start_a = 1'b0;
        check("R4 busy after start", busy_a, 1);
        if (hit) begin
            b2b_seen++;
            check("R5 start accepted in done cycle", busy_a, 1);
        end
    endtask

    task automatic wait_idle_a();
        @(negedge clk);
        while (busy_a) @(negedge clk);
    endtask

    // Small instance: run one argument and wait for it to settle
    task automatic run_b(input int n);
        #1;
        start_b = 1'b1;
        arg_b   = 8'(n);
        @(negedge clk);
        start_b = 1'b0;
        while (busy_b) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares every completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done_a) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected done", 1, 0);
            end else begin
                check("R1/R2 result", result_a, exp_q.pop_front());
            end
        end
        if (rst_n && done_b) done_b_cnt++;
    end

    // Watchdog ends a hung run as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        int unsigned held;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 busy", busy_a, 0);
        check("R8 done", done_a, 0);
        check("R8 result", result_a, 0);
        check("R8 overflow", ovf_a, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R5: back-to-back runs n = 0..15
        for (int n = 0; n <= 15; n++) run_a(n, 1'b1);
        wait_idle_a();
        @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        check("R5 back-to-back occurrences", (b2b_seen >= 10) ? 1 : 0, 1);

        // R3: result holds after the pulse
        held = result_a;
        repeat (5) @(negedge clk);
        check("R3 result held", result_a, held);
        check("R3 result is f(15)", result_a, ref_f(15));

        // R4: start while busy is ignored
        run_a(10, 1'b1);
        repeat (4) @(negedge clk);
        #1;
        start_a = 1'b1;
        arg_a   = 8'd3;
        @(negedge clk);
        start_a = 1'b0;
        wait_idle_a();
        repeat (20) @(negedge clk);
        check("R4 no extra run", busy_a, 0);
        check("R4 ignored start left result", result_a, ref_f(10));
        check("R4 scoreboard drained", exp_q.size(), 0);

        // R6, R7: four-frame instance
        run_b(4);
        check("R6 n=4 fits, done count", done_b_cnt, 1);
        check("R6 n=4 result", result_b, ref_f(4));
        check("R6 no overflow yet", ovf_b, 0);
        run_b(5);
        check("R6 overflow raised", ovf_b, 1);
        check("R6 no done on abort", done_b_cnt, 1);
        check("R6 idle after abort", busy_b, 0);
        run_b(3);
        check("R7 later run completes", done_b_cnt, 2);
        check("R7 later run result", result_b, ref_f(3));
        check("R7 overflow still high", ovf_b, 1);

        // R8: reset in the middle of a run
        run_a(12, 1'b0);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 mid-run busy", busy_a, 0);
        check("R8 mid-run done", done_a, 0);
        check("R8 mid-run result", result_a, 0);
        check("R8 overflow cleared", ovf_b, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_a(2, 1'b1);
        wait_idle_a();
        repeat (3) @(negedge clk);
        check("R8 run after reset drained", exp_q.size(), 0);
        check("R2 n=2 after reset", result_a, 3);

        summary();
    end

endmodule